// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block produces the serial clock of an I2C master on an open-drain line. It never drives the line high. It either pulls SCL low or lets it go. The line is read back through a two-flop synchronizer and an optional digital glitch filter. Every phase is timed from the moment that this read-back path reports the new level, not from the moment the block changes its own drive. Because of this, a target that stretches the clock, or another master that pulls the line low early, changes the period without any extra logic.

The low and high phases are timed in prescaled ticks. Each tick lasts `presc+1` kernel clocks. With no other device on the line and the filter length `N`, the block pulls the line low for `3+N+(low_cnt+1)(presc+1)` cycles. It then releases the line for `3+N+(high_cnt+1)(presc+1)` cycles. The fixed `3+N` is the detection delay: two synchronizer stages, the filter, and one cycle to start the count. On every transition that it detects, the block pulses a one-cycle strobe: one strobe for falling edges and one for rising edges. Start and stop conditions and data shifting belong to other blocks.

Top module: `i2c_scl_gen`

## Requirements
- R1: While reset is asserted, `scl_pull` is 0 and both strobes are 0. When `en` is low at a clock edge, `scl_pull` is 0 after that edge, and all counters return to idle.
- R2: The low phase is counted only after the read-back path reports the line low. The block then keeps `scl_pull`=1 for exactly (low_cnt+1)(presc+1) further cycles. With no other device on the line, each low pulse of `scl_pull` lasts 3+N+(low_cnt+1)(presc+1) cycles.
- R3: The high phase is counted only after the read-back path reports the line high. The block then keeps the line released for exactly (high_cnt+1)(presc+1) cycles before it pulls it low again. With no other device on the line, each released interval lasts 3+N+(high_cnt+1)(presc+1) cycles.
- R4: When `filt_len`=N is greater than 0, a new line level is accepted only after N consecutive synchronized samples of that level. A shorter pulse changes nothing. `filt_len`=0 bypasses the filter.
- R5: If the line stays low after release, the block waits with no limit. During the wait, `scl_pull` stays 0 and `rise_stb` stays 0. The high count starts 3+N cycles after the line goes high. Measured from a line rise placed half a cycle before a clock edge, the released interval is 3+N+(high_cnt+1)(presc+1) cycles.
- R6: While the high phase is being counted, another device may pull the line low. Once that low level is detected, the block asserts `scl_pull` and starts its low count from there. Measured from the external fall, `scl_pull` rises after 3+N cycles and stays high for (low_cnt+1)(presc+1) cycles.
- R7: `fall_stb` pulses for one cycle on each detected falling edge, and `rise_stb` pulses for one cycle on each detected rising edge. Each appears exactly once per clock period.
- R8: After `en` rises, the first phase is a high phase. Measured from the first edge at which `en` is high, `scl_pull` rises after 1+(high_cnt+1)(presc+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle with the line released |
| presc | input | 4 | Tick length minus one, in kernel clocks |
| low_cnt | input | 8 | Low phase length minus one, in ticks |
| high_cnt | input | 8 | High phase length minus one, in ticks |
| filt_len | input | 4 | Glitch filter length in kernel clocks, 0 = off |
| scl_in | input | 1 | Raw SCL line level |
| scl_pull | output | 1 | 1 = pull SCL low, 0 = release |
| fall_stb | output | 1 | One-cycle pulse on a detected falling edge |
| rise_stb | output | 1 | One-cycle pulse on a detected rising edge |

## Verification
The main sweep runs every combination of three prescaler values, three low counts, three high counts and two filter lengths on an undisturbed line. It separates a wrong tick length from a wrong phase count and from a wrong detection delay. A stretched release shows whether the high count waits for the line or starts on its own drive. A pull-down from a second master during the high count shows whether the low count restarts from the detected fall. With the filter on, a pulse one sample too short and a pulse of exactly the filter length show where the acceptance threshold lies.

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int PW = 4,
  parameter int CW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] presc,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] high_cnt,
  input  logic [FW-1:0] filt_len,
  input  logic          scl_in,
  output logic          scl_pull,
  output logic          fall_stb,
  output logic          rise_stb
);

  typedef enum logic [2:0] {S_IDLE, S_HWAIT, S_HCNT, S_LWAIT, S_LCNT} st_t;

  st_t           st;
  logic [1:0]    sync_q;
  logic          filt_q, det_d;
  logic [FW-1:0] fcnt;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] ph_q;

  wire scl_s = sync_q[1];
  wire det   = (filt_len == '0) ? scl_s : filt_q;
  wire tick  = (pre_q == '0);
  wire lo_done = tick && (ph_q == low_cnt);
  wire hi_done = tick && (ph_q == high_cnt);

  assign scl_pull = (st == S_LWAIT) || (st == S_LCNT);
  assign fall_stb = det_d & ~det;
  assign rise_stb = ~det_d & det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= 2'b11;
      det_d  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], scl_in};
      det_d  <= det;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      filt_q <= 1'b1;
      fcnt   <= '0;
    end else if (filt_len == '0 || scl_s == filt_q) begin
      filt_q <= scl_s;
      fcnt   <= '0;
    end else if (fcnt + 1'b1 == filt_len) begin
      filt_q <= scl_s;
      fcnt   <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      pre_q <= '0;
      ph_q  <= '0;
    end else if (!en) begin
      st    <= S_IDLE;
      pre_q <= '0;
      ph_q  <= '0;
    end else begin
      case (st)
        S_IDLE: st <= S_HWAIT;
        S_HWAIT: if (det) begin
          st    <= S_HCNT;
          pre_q <= presc;
          ph_q  <= '0;
        end
        S_LWAIT: if (!det) begin
          st    <= S_LCNT;
          pre_q <= presc;
          ph_q  <= '0;
        end
        S_HCNT:
          if (!det) begin
            st    <= S_LCNT;
            pre_q <= presc;
            ph_q  <= '0;
          end else if (hi_done) begin
            st <= S_LWAIT;
          end else if (tick) begin
            pre_q <= presc;
            ph_q  <= ph_q + 1'b1;
          end else begin
            pre_q <= pre_q - 1'b1;
          end
        S_LCNT:
          if (lo_done) begin
            st <= S_HWAIT;
          end else if (tick) begin
            pre_q <= presc;
            ph_q  <= ph_q + 1'b1;
          end else begin
            pre_q <= pre_q - 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end

  AST_EN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_pull); // R1
  AST_RELEASE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull) && en && $past(en)) |-> !$past(det)); // R2
  AST_LOW_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LCNT && $past(st == S_LCNT) && $stable(low_cnt)) |-> ph_q <= low_cnt); // R2
  AST_RISE_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> !scl_pull); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb); // R7

endmodule

// File: tb/test_i2c_scl_gen.sv
module test_i2c_scl_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, en, ext_low;
  logic [3:0] presc, filt_len;
  logic [7:0] low_cnt, high_cnt;
  logic scl_in, scl_pull, fall_stb, rise_stb;
  int total = 0, bad = 0;
  bit finished = 0;

  assign scl_in = ~(scl_pull | ext_low);

  i2c_scl_gen i_i2c_scl_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .presc(presc), .low_cnt(low_cnt),
    .high_cnt(high_cnt), .filt_len(filt_len), .scl_in(scl_in),
    .scl_pull(scl_pull), .fall_stb(fall_stb), .rise_stb(rise_stb));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wait_pull(input logic v);
    int k = 0;
    while (scl_pull !== v && k < 3000) begin @(negedge clk); k++; end
  endtask

  task automatic count_while(input logic v, output int n, output int nf, output int nr);
    n = 0; nf = 0; nr = 0;
    while (scl_pull === v && n < 5000) begin
      nf += int'(fall_stb); nr += int'(rise_stb); n++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int p, input int l, input int h, input int f);
    @(negedge clk);
    en = 0; ext_low = 0;
    presc = 4'(p); low_cnt = 8'(l); high_cnt = 8'(h); filt_len = 4'(f);
    repeat (8) @(negedge clk);
    en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int pv[3] = '{0, 1, 3};
    int lv[3] = '{0, 1, 4};
    int hv[3] = '{0, 2, 5};
    int fv[2] = '{0, 2};
    int n, nf, nr, n2, nf2, nr2, cnt;
    rst_n = 0; en = 0; ext_low = 0; presc = 0; low_cnt = 0; high_cnt = 0; filt_len = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset pull", int'(scl_pull), 0);
    chk("R1 reset strobes", int'(fall_stb | rise_stb), 0);
    rst_n = 1;

    // R2 R3 R7: sweep on an undisturbed line
    foreach (pv[a]) foreach (lv[b]) foreach (hv[c]) foreach (fv[d]) begin
      setup(pv[a], lv[b], hv[c], fv[d]);
      wait_pull(1);
      count_while(1, n, nf, nr);
      chk($sformatf("R2 low p=%0d l=%0d n=%0d", pv[a], lv[b], fv[d]), n,
          3 + fv[d] + (lv[b] + 1) * (pv[a] + 1));
      count_while(0, n2, nf2, nr2);
      chk($sformatf("R3 high p=%0d h=%0d n=%0d", pv[a], hv[c], fv[d]), n2,
          3 + fv[d] + (hv[c] + 1) * (pv[a] + 1));
      chk("R7 fall strobes per period", nf + nf2, 1);
      chk("R7 rise strobes per period", nr + nr2, 1);
    end

    // R1 disable and R8 first phase
    setup(1, 4, 2, 0);
    wait_pull(1);
    en = 0;
    @(negedge clk);
    chk("R1 release after disable", int'(scl_pull), 0);
    cnt = 0;
    repeat (20) begin cnt += int'(scl_pull); @(negedge clk); end
    chk("R1 stays released", cnt, 0);
    en = 1;
    @(negedge clk);
    count_while(0, n, nf, nr);
    chk("R8 first high phase", n, 1 + 3 * 2);

    // R5 stretch
    setup(1, 2, 3, 0);
    wait_pull(1); wait_pull(0);
    ext_low = 1;
    cnt = 0; nr = 0;
    repeat (20) begin cnt += int'(scl_pull); nr += int'(rise_stb); @(negedge clk); end
    chk("R5 no pull during stretch", cnt, 0);
    chk("R5 no rise during stretch", nr, 0);
    ext_low = 0;
    count_while(0, n, nf, nr);
    chk("R5 high after stretch", n, 3 + 4 * 2);

    // R6 second master pulls low during high count
    setup(1, 2, 5, 0);
    wait_pull(1); wait_pull(0);
    repeat (6) @(negedge clk);
    ext_low = 1;
    count_while(0, n, nf, nr);
    chk("R6 sync pull delay", n, 3);
    n = 0;
    while (scl_pull && n < 1000) begin
      if (n == 2) ext_low = 0;
      n++; @(negedge clk);
    end
    chk("R6 low counted from external fall", n, 3 * 2);

    // R4 short glitch rejected
    setup(1, 2, 5, 3);
    wait_pull(1); wait_pull(0);
    n = 0; nf = 0; nr = 0;
    while (!scl_pull && n < 1000) begin
      if (n == 9) ext_low = 1;
      if (n == 11) ext_low = 0;
      nf += int'(fall_stb); nr += int'(rise_stb);
      n++; @(negedge clk);
    end
    chk("R4 glitch rejected high length", n, 3 + 3 + 6 * 2);
    chk("R4 glitch no fall strobe", nf, 0);
    chk("R4 single rise strobe", nr, 1);

    // R4 pulse of exactly N accepted
    wait_pull(0);
    n = 0;
    while (!scl_pull && n < 1000) begin
      if (n == 9) ext_low = 1;
      if (n == 12) ext_low = 0;
      n++; @(negedge clk);
    end
    chk("R4 N-cycle pulse accepted", n, 9 + 3 + 3);

    summary();
  end
endmodule